// File: doc/BRIEF.md
# Banked Packed-Configuration GPIO Controller

This block is a bus-programmed general-purpose I/O controller with a parameterised pin count. Each pin has one 8-bit configuration byte. The bytes sit side by side in rows as wide as the bus data word, so one bus write programs every pin in a row. Row addresses are word indices. Pin `r*PPR+k`, where `PPR = DW/8`, lives in byte lane `k` of row `r`.

A 3-bit bank field in each byte sets who drives the pin. With bank 0 the bus owns the pin completely. With banks 1 to 3, one of three peripheral ports drives the pin's output, output enable and input enable, and receives its synchronised input. The pull-up and pull-down enables always come from the configuration byte. The external input passes through a two-flop synchroniser before any consumer sees it.

The bus side is a classic Wishbone slave. Software keeps its own shadow copy of each row, because a write always replaces every byte in that row.

Top module: `pinbank_gpio`

## Requirements
- R1: After reset every configuration byte is zero. All pad outputs (`pad_out`, `pad_oe`, `pad_ie`, `pad_pu`, `pad_pd`) are low, every row reads back zero, and `prph_in` is all zero.
- R2: Byte layout: bit 0 is the i/o data bit, bit 1 output enable, bit 2 input enable, bit 3 pull-up enable, bit 4 pull-down enable, and bits 7:5 the bank number. Pin `r*PPR+k` uses bits `8k+7:8k` of row `r`, and a read returns bits 7:1 as stored.
- R3: A written byte with bit 1 set stores bit 0 as the pin's output value. When bit 1 of the written byte is clear, bit 0 is ignored and the stored output value is kept.
- R4: Read bit 0 of a pin is its synchronised input level when its input enable is set, and 0 otherwise. A pad change becomes visible after two rising clock edges.
- R5: In bank 0, `pad_out`, `pad_oe` and `pad_ie` equal the pin's stored output value, output enable and input enable.
- R6: In bank b (1..3), `pad_out`, `pad_oe` and `pad_ie` of pin p come from bit `(b-1)*NPINS+p` of `prph_out`, `prph_oe` and `prph_ie`. That same bit of `prph_in` carries the synchronised input when the pin is in bank b and the port's `prph_ie` bit is set, and 0 in every other case.
- R7: Bank values 4 to 7 leave the pad undriven: `pad_out`, `pad_oe` and `pad_ie` are low, and no peripheral receives the input.
- R8: `pad_pu` and `pad_pd` follow the stored pull-up and pull-down enables in every bank.
- R9: A write updates every byte of the addressed row in the same clock edge and leaves all other rows unchanged.
- R10: An access to a row at or beyond `ceil(NPINS/PPR)` is acknowledged, reads back zero and changes no pin.
- R11: `wb_ack` rises one clock after `wb_cyc` and `wb_stb` are both high, and lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wb_cyc | input | 1 | Bus cycle |
| wb_stb | input | 1 | Bus strobe |
| wb_we | input | 1 | Write enable |
| wb_adr | input | ADDR_W | Row index (word address) |
| wb_dat_w | input | DW | Write data, one byte per pin |
| wb_dat_r | output | DW | Read data, one byte per pin |
| wb_ack | output | 1 | Single-cycle acknowledge |
| pad_in | input | NPINS | Raw pad input levels |
| pad_out | output | NPINS | Pad output value |
| pad_oe | output | NPINS | Pad output enable |
| pad_ie | output | NPINS | Pad input buffer enable |
| pad_pu | output | NPINS | Pull-up enable |
| pad_pd | output | NPINS | Pull-down enable |
| prph_out | input | NB*NPINS | Peripheral output value, bank-major |
| prph_oe | input | NB*NPINS | Peripheral output enable, bank-major |
| prph_ie | input | NB*NPINS | Peripheral input enable, bank-major |
| prph_in | output | NB*NPINS | Synchronised input delivered to peripherals |

## Verification
The assertions assume a bus master that drops `wb_stb` in the cycle after it sees `wb_ack`, so each request is served once. The bench tasks always release the strobe right after sampling the acknowledge.

The checks on `prph_in` and readback assume that `pad_in` has been stable for two clock edges. The stimulus changes the pads at a falling edge and waits three cycles before it looks at any input-derived value. The random rows include indices past the last real row, and the random bytes include the spare bank codes, so both of those paths get regular traffic.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

  localparam int unsigned CFG_W     = 8;
  localparam int unsigned BANK_W    = 3;
  localparam logic [BANK_W-1:0] BANK_BUS = '0;

  typedef struct packed {
    logic [BANK_W-1:0] bank;
    logic              pden;
    logic              puen;
    logic              ie;
    logic              oe;
    logic              io;
  } pin_cfg_t;

  // New byte replaces the old one; the data bit is only taken with oe set.
  function automatic pin_cfg_t merge_cfg(pin_cfg_t cur, logic [CFG_W-1:0] wbyte);
    pin_cfg_t nxt;
    nxt = pin_cfg_t'(wbyte);
    if (!nxt.oe) nxt.io = cur.io;
    return nxt;
  endfunction

endpackage

// File: rtl/gpr_rst_sync.sv
module gpr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= '0;
    else         stage_q <= stage_d;
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/gpr_sync.sv
module gpr_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta_q;
  logic [W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= din;
      hold_q <= meta_q;
    end
  end

  assign dout = hold_q;
endmodule

// File: rtl/gpr_cfg_regs.sv
module gpr_cfg_regs
  import gpr_pkg::*;
#(
  parameter int unsigned NPINS  = 16,
  parameter int unsigned DW     = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cyc,
  input  logic                   stb,
  input  logic                   we,
  input  logic [ADDR_W-1:0]      adr,
  input  logic [DW-1:0]          dat_w,
  input  logic [NPINS-1:0]       in_sync,
  output logic [DW-1:0]          dat_r,
  output logic                   ack,
  output pin_cfg_t [NPINS-1:0]   cfg_o
);
  localparam int unsigned PPR  = DW / CFG_W;
  localparam int unsigned ROWS = (NPINS + PPR - 1) / PPR;

  pin_cfg_t [NPINS-1:0] cfg_q;
  pin_cfg_t [NPINS-1:0] cfg_d;
  logic [NPINS-1:0]     wr_hit;
  logic [DW-1:0]        rd_sel;
  logic [DW-1:0]        dat_r_d;
  logic                 req;
  logic                 ack_d;
  logic                 oob;

  assign req = cyc & stb & ~ack;
  assign oob = (32'(adr) >= ROWS);

  // Next state of every configuration byte.
  always_comb begin
    for (int p = 0; p < NPINS; p++) begin
      wr_hit[p] = req & we & (adr == ADDR_W'(p / PPR));
      cfg_d[p]  = wr_hit[p] ? merge_cfg(cfg_q[p], dat_w[(p % PPR)*CFG_W +: CFG_W])
                            : cfg_q[p];
    end
  end

  // Readback row: stored bits 7:1, gated live input in bit 0.
  always_comb begin
    rd_sel = '0;
    for (int p = 0; p < NPINS; p++) begin
      if (adr == ADDR_W'(p / PPR))
        rd_sel[(p % PPR)*CFG_W +: CFG_W] = {cfg_q[p][CFG_W-1:1], cfg_q[p].ie & in_sync[p]};
    end
  end

  always_comb begin
    dat_r_d = (req & ~we) ? rd_sel : '0;
    ack_d   = req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      dat_r <= '0;
      ack   <= 1'b0;
    end else begin
      if (|wr_hit) cfg_q <= cfg_d;
      dat_r <= dat_r_d;
      ack   <= ack_d;
    end
  end

  assign cfg_o = cfg_q;

  // R11: acknowledge one cycle after request, single-cycle pulse
  a_r11_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc && stb && !ack) |=> ack);
  a_r11_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  // R10: out-of-range row touches nothing and reads zero
  a_r10_oob_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (req && oob) |=> $stable(cfg_q));
  a_r10_oob_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req && oob && !we) |=> (dat_r == '0));

  for (genvar p = 0; p < NPINS; p++) begin : g_chk
    // R3: data bit kept when the written byte has oe clear
    a_r3_io_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit[p] && !dat_w[(p % PPR)*CFG_W + 1]) |=> (cfg_q[p].io == $past(cfg_q[p].io)));
    // R9: writes to another row leave this pin alone
    a_r9_row_isolated: assert property (@(posedge clk) disable iff (!rst_n)
      (req && we && (adr != ADDR_W'(p / PPR))) |=> $stable(cfg_q[p]));
  end
endmodule

// File: rtl/gpr_pad_mux.sv
module gpr_pad_mux
  import gpr_pkg::*;
#(
  parameter int unsigned NPINS = 16,
  parameter int unsigned NB    = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  pin_cfg_t [NPINS-1:0]    cfg,
  input  logic [NPINS-1:0]        in_sync,
  input  logic [NB*NPINS-1:0]     per_o,
  input  logic [NB*NPINS-1:0]     per_oe,
  input  logic [NB*NPINS-1:0]     per_ie,
  output logic [NB*NPINS-1:0]     per_i,
  output logic [NPINS-1:0]        pad_o,
  output logic [NPINS-1:0]        pad_oe,
  output logic [NPINS-1:0]        pad_ie,
  output logic [NPINS-1:0]        pad_pu,
  output logic [NPINS-1:0]        pad_pd
);
  always_comb begin
    per_i = '0;
    for (int p = 0; p < NPINS; p++) begin
      pad_pu[p] = cfg[p].puen;
      pad_pd[p] = cfg[p].pden;
      pad_o[p]  = 1'b0;
      pad_oe[p] = 1'b0;
      pad_ie[p] = 1'b0;
      if (cfg[p].bank == BANK_BUS) begin
        pad_o[p]  = cfg[p].io;
        pad_oe[p] = cfg[p].oe;
        pad_ie[p] = cfg[p].ie;
      end
      for (int b = 1; b <= NB; b++) begin
        if (cfg[p].bank == BANK_W'(b)) begin
          pad_o[p]  = per_o[(b-1)*NPINS + p];
          pad_oe[p] = per_oe[(b-1)*NPINS + p];
          pad_ie[p] = per_ie[(b-1)*NPINS + p];
          per_i[(b-1)*NPINS + p] = per_ie[(b-1)*NPINS + p] & in_sync[p];
        end
      end
    end
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_chk
    logic [NB-1:0] sinks;
    for (genvar b = 0; b < NB; b++) begin : g_sink
      assign sinks[b] = per_i[b*NPINS + p];
    end
    // R6: a pin's input reaches at most one peripheral port
    a_r6_single_sink: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sinks));
    // R7: spare bank codes leave the pad undriven and unshared
    a_r7_spare_off: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(cfg[p].bank) > NB) |-> (!pad_oe[p] && !pad_ie[p] && !pad_o[p] && (sinks == '0)));
  end
endmodule

// File: rtl/pinbank_gpio.sv
module pinbank_gpio #(
  parameter int unsigned NPINS  = 16,
  parameter int unsigned DW     = 32,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned NB     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wb_cyc,
  input  logic                 wb_stb,
  input  logic                 wb_we,
  input  logic [ADDR_W-1:0]    wb_adr,
  input  logic [DW-1:0]        wb_dat_w,
  output logic [DW-1:0]        wb_dat_r,
  output logic                 wb_ack,
  input  logic [NPINS-1:0]     pad_in,
  output logic [NPINS-1:0]     pad_out,
  output logic [NPINS-1:0]     pad_oe,
  output logic [NPINS-1:0]     pad_ie,
  output logic [NPINS-1:0]     pad_pu,
  output logic [NPINS-1:0]     pad_pd,
  input  logic [NB*NPINS-1:0]  prph_out,
  input  logic [NB*NPINS-1:0]  prph_oe,
  input  logic [NB*NPINS-1:0]  prph_ie,
  output logic [NB*NPINS-1:0]  prph_in
);
  import gpr_pkg::*;

  logic                 srst_n;
  logic [NPINS-1:0]     in_sync;
  pin_cfg_t [NPINS-1:0] cfg;

  gpr_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  gpr_sync #(.W(NPINS)) u_sync (
    .clk   (clk),
    .rst_n (srst_n),
    .din   (pad_in),
    .dout  (in_sync)
  );

  gpr_cfg_regs #(.NPINS(NPINS), .DW(DW), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (srst_n),
    .cyc     (wb_cyc),
    .stb     (wb_stb),
    .we      (wb_we),
    .adr     (wb_adr),
    .dat_w   (wb_dat_w),
    .in_sync (in_sync),
    .dat_r   (wb_dat_r),
    .ack     (wb_ack),
    .cfg_o   (cfg)
  );

  gpr_pad_mux #(.NPINS(NPINS), .NB(NB)) u_mux (
    .clk     (clk),
    .rst_n   (srst_n),
    .cfg     (cfg),
    .in_sync (in_sync),
    .per_o   (prph_out),
    .per_oe  (prph_oe),
    .per_ie  (prph_ie),
    .per_i   (prph_in),
    .pad_o   (pad_out),
    .pad_oe  (pad_oe),
    .pad_ie  (pad_ie),
    .pad_pu  (pad_pu),
    .pad_pd  (pad_pd)
  );
endmodule

// File: tb/pinbank_gpio_tb.sv
module pinbank_gpio_tb_top;
  localparam int NP = 16, DW = 32, AW = 4, NB = 3;
  localparam int PPR = DW / 8, ROWS = NP / PPR;

  logic clk = 1'b0;
  logic rst_n;
  logic cyc, stb, we;
  logic [AW-1:0] adr;
  logic [DW-1:0] dat_w, dat_r;
  logic ack;
  logic [NP-1:0] pad_in, pad_out, pad_oe, pad_ie, pad_pu, pad_pd;
  logic [NB*NP-1:0] prph_out, prph_oe, prph_ie, prph_in;

  int total = 0, bad = 0;
  logic [7:0] m [NP];

  always #4 clk = ~clk;

  pinbank_gpio #(.NPINS(NP), .DW(DW), .ADDR_W(AW), .NB(NB)) dut_i (
    .clk(clk), .rst_n(rst_n), .wb_cyc(cyc), .wb_stb(stb), .wb_we(we),
    .wb_adr(adr), .wb_dat_w(dat_w), .wb_dat_r(dat_r), .wb_ack(ack),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_ie(pad_ie),
    .pad_pu(pad_pu), .pad_pd(pad_pd), .prph_out(prph_out), .prph_oe(prph_oe),
    .prph_ie(prph_ie), .prph_in(prph_in));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  function automatic logic [7:0] mrg(logic [7:0] old, logic [7:0] nw);
    logic [7:0] r;
    r = nw;
    if (!nw[1]) r[0] = old[0];
    return r;
  endfunction

  function automatic logic [DW-1:0] exp_row(int row);
    logic [DW-1:0] r = '0;
    if (row < ROWS)
      for (int l = 0; l < PPR; l++) begin
        int p = row * PPR + l;
        r[l*8 +: 8] = {m[p][7:1], m[p][2] & pad_in[p]};
      end
    return r;
  endfunction

  task automatic xfer(input logic w, input int row, input logic [DW-1:0] wd, output logic [DW-1:0] rd);
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = w; adr = AW'(row); dat_w = wd;
    @(negedge clk);
    chk(ack === 1'b1, "R11 ack rise", 64'(ack), 64'd1);
    rd = dat_r;
    cyc = 1'b0; stb = 1'b0; we = 1'b0;
    @(negedge clk);
    chk(ack === 1'b0, "R11 ack pulse", 64'(ack), 64'd0);
    if (w && row < ROWS)
      for (int l = 0; l < PPR; l++) m[row*PPR+l] = mrg(m[row*PPR+l], wd[l*8 +: 8]);
  endtask

  task automatic wr(input int row, input logic [DW-1:0] wd);
    logic [DW-1:0] dummy;
    xfer(1'b1, row, wd, dummy);
  endtask

  task automatic rd_chk(input int row, input string req);
    logic [DW-1:0] got, exp;
    exp = exp_row(row);
    xfer(1'b0, row, '0, got);
    chk(got === exp, req, 64'(got), 64'(exp));
  endtask

  task automatic check_pads();
    logic [NB*NP-1:0] ei;
    ei = '0;
    for (int p = 0; p < NP; p++) begin
      int b = int'(m[p][7:5]);
      logic [2:0] e, a;
      a = {pad_out[p], pad_oe[p], pad_ie[p]};
      if (b == 0) begin
        e = {m[p][0], m[p][1], m[p][2]};
        chk(a === e, "R5 bus bank pad", 64'(a), 64'(e));
      end else if (b <= NB) begin
        int ix = (b-1)*NP + p;
        e = {prph_out[ix], prph_oe[ix], prph_ie[ix]};
        ei[ix] = prph_ie[ix] & pad_in[p];
        chk(a === e, "R6 peripheral bank pad", 64'(a), 64'(e));
      end else begin
        e = 3'b000;
        chk(a === e, "R7 spare bank pad", 64'(a), 64'(e));
      end
      chk({pad_pu[p], pad_pd[p]} === {m[p][3], m[p][4]}, "R8 pulls",
          64'({pad_pu[p], pad_pd[p]}), 64'({m[p][3], m[p][4]}));
    end
    chk(prph_in === ei, "R6/R7 prph_in", 64'(prph_in), 64'(ei));
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int p = 0; p < NP; p++) m[p] = 8'h00;
    cyc = 0; stb = 0; we = 0; adr = '0; dat_w = '0;
    pad_in = 16'hA5C3; prph_out = '0; prph_oe = '0; prph_ie = '0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk({pad_out, pad_oe, pad_ie, pad_pu, pad_pd} === '0, "R1 pads zero",
        64'({pad_out, pad_oe, pad_ie}), 64'd0);
    chk(prph_in === '0, "R1 prph_in zero", 64'(prph_in), 64'd0);
    for (int r = 0; r < ROWS; r++) rd_chk(r, "R1 reset readback");

    // R2 and R9: distinct bytes in row 1, all lanes updated together
    wr(1, 32'h1E_0F_18_0E);
    rd_chk(1, "R2 byte layout readback");
    rd_chk(0, "R9 other row untouched");
    check_pads();

    // R3: data bit honoured only with oe set
    wr(0, 32'h0000_0003);
    settle();
    chk(pad_out[0] === 1'b1, "R3 io set with oe", 64'(pad_out[0]), 64'd1);
    wr(0, 32'h0000_0000);
    chk(pad_out[0] === 1'b1, "R3 io kept with oe clear", 64'(pad_out[0]), 64'd1);
    wr(0, 32'h0000_0002);
    chk(pad_out[0] === 1'b0, "R3 io cleared with oe", 64'(pad_out[0]), 64'd0);

    // R4: input readback gated by ie, through the synchroniser
    wr(0, 32'h0000_0004);
    pad_in[0] = 1'b1; settle();
    rd_chk(0, "R4 input high with ie");
    pad_in[0] = 1'b0; settle();
    rd_chk(0, "R4 input low with ie");
    wr(0, 32'h0000_0000);
    pad_in[0] = 1'b1; settle();
    rd_chk(0, "R4 input masked without ie");

    // R10: out-of-range row
    wr(ROWS + 1, 32'hFFFF_FFFF);
    check_pads();
    rd_chk(ROWS + 1, "R10 oob reads zero");
    rd_chk(0, "R10 row 0 unchanged");

    // R6/R7: peripheral banks and spare codes
    prph_out = '1; prph_oe = '1; prph_ie = '1;
    wr(2, 32'hE0_60_40_20);
    pad_in = '1; settle();
    check_pads();

    // Random mix
    for (int it = 0; it < 120; it++) begin
      int row = int'($urandom % (ROWS + 2));
      wr(row, $urandom);
      prph_out = {$urandom, $urandom}; prph_oe = {$urandom, $urandom};
      prph_ie  = {$urandom, $urandom}; pad_in = NP'($urandom);
      settle();
      check_pads();
      rd_chk(int'($urandom % (ROWS + 2)), "R2/R4/R10 random readback");
    end

    finish_run();
  end
endmodule